// File: doc/BRIEF.md
# SMRAM and TSEG Access Router

This block holds the two control bytes that govern system-management memory and classifies every memory request against them. Each request carries an address, a read/write flag and a flag that says whether the requester runs in system-management mode (SMM). One cycle later the block returns a route: to RAM, with the RAM address to use, to the external bus, or to a dummy sink. A sink read returns all ones and a sink write is dropped.

Three address regions are governed. The first is the legacy window at 0xA0000..0xBFFFF (128 KiB). The second is a high alias window at 0xFEDA0000 that mirrors the legacy window onto the same RAM bytes. The third is a protected segment (TSEG) that ends at the configured top of low memory and whose size comes from a two-bit code. Any address outside the three regions goes to RAM when it lies below the top of low memory, and to the bus otherwise. A lock bit makes the control settings read-only until the next reset, and it also forces the window-open bit to zero.

Register byte 0 (control) has bit 0 as the window-open bit, bit 1 as the lock and bit 2 as the SMM global enable. Register byte 1 (extended) has bit 0 as the high-enable bit, bit 1 as the TSEG enable and bits 3:2 as the TSEG size code.

Top module: `smram_route_ctrl`

## Requirements
- R1: After reset both bytes are zero. A non-SMM or SMM access to the legacy window or the high window routes to the bus (route code 1), and the TSEG region is disabled.
- R2: rsp_valid rises exactly one cycle after req_valid. A register write presented in the same cycle as a request takes effect for the next request, not that one.
- R3: Writing control bit 1 = 1 sets the lock and leaves the open bit (control bit 0) at 0 even if it was written 1. While locked, writes to either byte change nothing.
- R4: With the open bit set, a non-SMM legacy-window access routes to RAM (route code 0) at its own address when high-enable (extended bit 0) is 0, and to the bus when it is 1.
- R5: With the open bit clear, non-SMM accesses to the legacy window and to the high window route to the bus.
- R6: With the open bit and high-enable both set, a non-SMM high-window access routes to RAM at address − 0xFEDA0000 + 0xA0000.
- R7: With the global enable (control bit 2) set, an SMM legacy-window access routes to RAM when high-enable is 0, and an SMM high-window access routes to translated RAM when high-enable is 1. With the global enable clear, SMM accesses follow the non-SMM rules.
- R8: With the TSEG enable (extended bit 1) set, size code 0/1/2/3 selects 1/2/8 MiB or the EXT_TSEG_MB parameter in MiB. The region spans [tolm − size, tolm).
- R9: In TSEG a non-SMM read routes to the sink (route code 2) with rsp_rdata = 0xFFFFFFFF, a non-SMM write routes to the sink with rsp_drop = 1, and an SMM access routes to RAM.
- R10: Outside all regions an address below tolm routes to RAM at its own address and any other address routes to the bus. rsp_ram_addr is 0 unless the route is RAM.
- R11: Reset after a lock clears the lock and restores full writability of both bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the control byte, 1 the extended byte |
| cfg_wdata | input | 8 | Register write data |
| tolm | input | ADDR_W | Top of low memory (exclusive) |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_smm | input | 1 | Requester is in system-management mode |
| rsp_valid | output | 1 | Route result valid |
| rsp_route | output | 2 | 0 RAM, 1 bus, 2 sink |
| rsp_ram_addr | output | ADDR_W | RAM address when routed to RAM, else 0 |
| rsp_rdata | output | 32 | All ones for a sink read, else 0 |
| rsp_drop | output | 1 | Write discarded by the sink |

## Verification
A route result appears on the outputs one clock edge after its request is sampled. A register write becomes visible to requests sampled one edge after the write. The bench drives requests and writes on the falling edge and pushes the expected result, computed from shadow copies of the two bytes, into a queue in that same cycle. The monitor pops and compares on the next falling edge, which is the first point where the registered result is stable. A same-cycle write and request checks that the old settings apply to that request.

// File: rtl/smr_pkg.sv
package smr_pkg;

    typedef enum logic [1:0] {
        ROUTE_RAM  = 2'd0,
        ROUTE_BUS  = 2'd1,
        ROUTE_SINK = 2'd2
    } route_e;

    // control byte: [2] global SMM enable, [1] lock, [0] window open
    typedef struct packed {
        logic glob_en;
        logic lock;
        logic open;
    } ctl_t;

    // extended byte: [3:2] size code, [1] TSEG enable, [0] high enable
    typedef struct packed {
        logic [1:0] tseg_code;
        logic       tseg_en;
        logic       high_en;
    } ext_t;

    typedef struct packed {
        logic hit_low;
        logic hit_high;
        logic hit_tseg;
        logic below_tolm;
    } win_t;

    localparam int CTL_W = $bits(ctl_t);
    localparam int EXT_W = $bits(ext_t);

    localparam logic [CTL_W-1:0] CTL_MASK_OPEN   = '1;
    localparam logic [CTL_W-1:0] CTL_MASK_LOCKED = '0;
    localparam logic [EXT_W-1:0] EXT_MASK_OPEN   = '1;
    localparam logic [EXT_W-1:0] EXT_MASK_LOCKED = '0;

    localparam int MIB_SHIFT = 20;

    function automatic logic [15:0] tseg_mib(input logic en,
                                             input logic [1:0] code,
                                             input logic [15:0] ext_mb);
        logic [15:0] r;
        if (!en) begin
            r = 16'd0;
        end else begin
            case (code)
                2'd0:    r = 16'd1;
                2'd1:    r = 16'd2;
                2'd2:    r = 16'd8;
                default: r = ext_mb;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/smr_regs.sv
module smr_regs
    import smr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic       cfg_sel,
    input  logic [7:0] cfg_wdata,
    output ctl_t       ctl_q,
    output ext_t       ext_q
);

    logic [CTL_W-1:0] ctl_mask;
    logic [EXT_W-1:0] ext_mask;
    ctl_t             ctl_nxt;
    ext_t             ext_nxt;

    always_comb begin
        ctl_mask = ctl_q.lock ? CTL_MASK_LOCKED : CTL_MASK_OPEN;
        ext_mask = ctl_q.lock ? EXT_MASK_LOCKED : EXT_MASK_OPEN;
        ctl_nxt  = ctl_q;
        ext_nxt  = ext_q;
        if (cfg_we && !cfg_sel) begin
            ctl_nxt = ctl_t'((ctl_q & ~ctl_mask) | (cfg_wdata[CTL_W-1:0] & ctl_mask));
        end
        if (cfg_we && cfg_sel) begin
            ext_nxt = ext_t'((ext_q & ~ext_mask) | (cfg_wdata[EXT_W-1:0] & ext_mask));
        end
        // a set lock always keeps the window closed
        if (ctl_nxt.lock) begin
            ctl_nxt.open = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            ext_q <= '0;
        end else begin
            ctl_q <= ctl_nxt;
            ext_q <= ext_nxt;
        end
    end

endmodule

// File: rtl/smr_decode.sv
module smr_decode
    import smr_pkg::*;
#(
    parameter int unsigned          ADDR_W      = 32,
    parameter int unsigned          EXT_TSEG_MB = 16,
    parameter logic [ADDR_W-1:0]    LOW_BASE    = 'h000A_0000,
    parameter logic [ADDR_W-1:0]    HIGH_BASE   = 'hFEDA_0000,
    parameter logic [ADDR_W-1:0]    WIN_BYTES   = 'h0002_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] tolm,
    input  logic              tseg_en,
    input  logic [1:0]        tseg_code,
    output win_t              win,
    output logic [ADDR_W-1:0] alias_addr
);

    localparam logic [ADDR_W-1:0] LOW_END  = LOW_BASE + WIN_BYTES;
    localparam logic [ADDR_W-1:0] HIGH_END = HIGH_BASE + WIN_BYTES;

    logic [15:0]       mib;
    logic [ADDR_W-1:0] tseg_size;
    logic [ADDR_W-1:0] tseg_base;

    always_comb begin
        mib       = tseg_mib(tseg_en, tseg_code, 16'(EXT_TSEG_MB));
        tseg_size = ADDR_W'(mib) << MIB_SHIFT;
        tseg_base = tolm - tseg_size;

        win.hit_low    = (addr >= LOW_BASE)  && (addr < LOW_END);
        win.hit_high   = (addr >= HIGH_BASE) && (addr < HIGH_END);
        win.hit_tseg   = (tseg_size != '0) && (addr >= tseg_base) && (addr < tolm);
        win.below_tolm = (addr < tolm);

        alias_addr = addr - HIGH_BASE + LOW_BASE;
    end

endmodule

// File: rtl/smr_router.sv
module smr_router
    import smr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_smm,
    input  win_t              win,
    input  logic [ADDR_W-1:0] alias_addr,
    input  logic              open,
    input  logic              glob_en,
    input  logic              high_en,
    output logic              rsp_valid,
    output route_e            rsp_route,
    output logic [ADDR_W-1:0] rsp_ram_addr,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_drop
);

    route_e            route;
    logic [ADDR_W-1:0] ram_addr;
    logic              smm_view;

    always_comb begin
        smm_view = req_smm && glob_en;
        route    = ROUTE_BUS;
        ram_addr = req_addr;
        if (smm_view && win.hit_low && !high_en) begin
            route = ROUTE_RAM;
        end else if (smm_view && win.hit_high && high_en) begin
            route    = ROUTE_RAM;
            ram_addr = alias_addr;
        end else if (win.hit_low) begin
            route = (open && !high_en) ? ROUTE_RAM : ROUTE_BUS;
        end else if (win.hit_high) begin
            route    = (open && high_en) ? ROUTE_RAM : ROUTE_BUS;
            ram_addr = alias_addr;
        end else if (win.hit_tseg) begin
            route = req_smm ? ROUTE_RAM : ROUTE_SINK;
        end else begin
            route = win.below_tolm ? ROUTE_RAM : ROUTE_BUS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_route    <= ROUTE_BUS;
            rsp_ram_addr <= '0;
            rsp_rdata    <= '0;
            rsp_drop     <= 1'b0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_route    <= req_valid ? route : ROUTE_BUS;
            rsp_ram_addr <= (req_valid && route == ROUTE_RAM) ? ram_addr : '0;
            rsp_rdata    <= (req_valid && route == ROUTE_SINK && !req_write) ? '1 : '0;
            rsp_drop     <= req_valid && route == ROUTE_SINK && req_write;
        end
    end

endmodule

// File: rtl/smram_route_ctrl.sv
module smram_route_ctrl
    import smr_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       EXT_TSEG_MB = 16,
    parameter logic [ADDR_W-1:0] LOW_BASE    = 'h000A_0000,
    parameter logic [ADDR_W-1:0] HIGH_BASE   = 'hFEDA_0000,
    parameter logic [ADDR_W-1:0] WIN_BYTES   = 'h0002_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [7:0]        cfg_wdata,
    input  logic [ADDR_W-1:0] tolm,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_smm,
    output logic              rsp_valid,
    output logic [1:0]        rsp_route,
    output logic [ADDR_W-1:0] rsp_ram_addr,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_drop
);

    ctl_t              ctl_q;
    ext_t              ext_q;
    win_t              win;
    logic [ADDR_W-1:0] alias_addr;
    route_e            route_q;

    smr_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ctl_q     (ctl_q),
        .ext_q     (ext_q)
    );

    smr_decode #(
        .ADDR_W      (ADDR_W),
        .EXT_TSEG_MB (EXT_TSEG_MB),
        .LOW_BASE    (LOW_BASE),
        .HIGH_BASE   (HIGH_BASE),
        .WIN_BYTES   (WIN_BYTES)
    ) u_decode (
        .addr       (req_addr),
        .tolm       (tolm),
        .tseg_en    (ext_q.tseg_en),
        .tseg_code  (ext_q.tseg_code),
        .win        (win),
        .alias_addr (alias_addr)
    );

    smr_router #(
        .ADDR_W (ADDR_W)
    ) u_router (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_write    (req_write),
        .req_smm      (req_smm),
        .win          (win),
        .alias_addr   (alias_addr),
        .open         (ctl_q.open),
        .glob_en      (ctl_q.glob_en),
        .high_en      (ext_q.high_en),
        .rsp_valid    (rsp_valid),
        .rsp_route    (route_q),
        .rsp_ram_addr (rsp_ram_addr),
        .rsp_rdata    (rsp_rdata),
        .rsp_drop     (rsp_drop)
    );

    assign rsp_route = route_q;

endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
    parameter int unsigned       ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 'hFEDA_0000,
    parameter logic [ADDR_W-1:0] WIN_BYTES = 'h0002_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_smm,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [1:0]        rsp_route,
    input logic [ADDR_W-1:0] rsp_ram_addr,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_drop,
    input logic [1:0]        lock_open,
    input logic [3:0]        ext_q
);

    localparam logic [ADDR_W-1:0] HI_END = HIGH_BASE + WIN_BYTES;

    logic in_high;
    assign in_high = (req_addr >= HIGH_BASE) && (req_addr < HI_END);

    p_lock_clears_open_r3: assert property (@(posedge clk) disable iff (rst)
        lock_open[1] |-> !lock_open[0]);

    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        lock_open[1] |=> lock_open[1]);

    p_locked_ext_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        lock_open[1] |=> $stable(ext_q));

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_no_rsp_without_req_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_smm_never_sink_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_smm) |=> (rsp_route != 2'd2));

    p_sink_payload_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_route == 2'd2) |-> ((rsp_drop || rsp_rdata == 32'hFFFF_FFFF) && rsp_ram_addr == '0));

    p_hidden_high_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_smm && !lock_open[0] && in_high) |=> (rsp_route == 2'd1));

endmodule

bind smram_route_ctrl smr_checker #(
    .ADDR_W    (ADDR_W),
    .HIGH_BASE (HIGH_BASE),
    .WIN_BYTES (WIN_BYTES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_smm      (req_smm),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_route    (rsp_route),
    .rsp_ram_addr (rsp_ram_addr),
    .rsp_rdata    (rsp_rdata),
    .rsp_drop     (rsp_drop),
    .lock_open    (ctl_q[1:0]),
    .ext_q        (ext_q)
);

// File: tb/smram_route_ctrl_test.sv
module smram_route_ctrl_test;

    localparam int          CLK_PERIOD = 10;
    localparam int          WATCHDOG   = 20000;
    localparam logic [31:0] TOLM       = 32'h8000_0000;
    localparam int          EXT_MB     = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [31:0] tolm = TOLM;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_smm = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_route;
    logic [31:0] rsp_ram_addr;
    logic [31:0] rsp_rdata;
    logic        rsp_drop;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smram_route_ctrl uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .tolm(tolm), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .req_smm(req_smm),
        .rsp_valid(rsp_valid), .rsp_route(rsp_route),
        .rsp_ram_addr(rsp_ram_addr), .rsp_rdata(rsp_rdata), .rsp_drop(rsp_drop)
    );

    typedef struct {
        logic [1:0]  route;
        logic [31:0] ram;
        logic [31:0] rdata;
        logic        drop;
        string       tag;
    } exp_t;

    exp_t q[$];

    // shadow of the register bytes, kept from the requirement text
    logic s_open, s_lock, s_glob, s_high, s_ten;
    logic [1:0] s_code;

    task automatic shadow_reset();
        s_open = 0; s_lock = 0; s_glob = 0; s_high = 0; s_ten = 0; s_code = 0;
    endtask

    task automatic shadow_write(input logic sel, input logic [7:0] d);
        if (!s_lock) begin
            if (!sel) begin
                s_glob = d[2];
                s_lock = d[1];
                s_open = d[1] ? 1'b0 : d[0];
            end else begin
                s_high = d[0];
                s_ten  = d[1];
                s_code = d[3:2];
            end
        end
    endtask

    function automatic exp_t model(input logic [31:0] a, input logic smm,
                                   input logic wr, input string tag);
        exp_t e;
        logic low, high, tseg, sv;
        logic [31:0] sz, xl;
        low  = a >= 32'h000A_0000 && a < 32'h000C_0000;
        high = a >= 32'hFEDA_0000 && a < 32'hFEDC_0000;
        xl   = a - 32'hFEDA_0000 + 32'h000A_0000;
        if (!s_ten)            sz = 0;
        else if (s_code == 0)  sz = 32'h0010_0000;
        else if (s_code == 1)  sz = 32'h0020_0000;
        else if (s_code == 2)  sz = 32'h0080_0000;
        else                   sz = EXT_MB * 32'h0010_0000;
        tseg = sz != 0 && a >= TOLM - sz && a < TOLM;
        sv   = smm && s_glob;
        e.ram = a; e.tag = tag; e.rdata = 0; e.drop = 0;
        if (sv && low && !s_high)        e.route = 0;
        else if (sv && high && s_high) begin e.route = 0; e.ram = xl; end
        else if (low)                    e.route = (s_open && !s_high) ? 2'd0 : 2'd1;
        else if (high) begin e.route = (s_open && s_high) ? 2'd0 : 2'd1; e.ram = xl; end
        else if (tseg)                   e.route = smm ? 2'd0 : 2'd2;
        else                             e.route = (a < TOLM) ? 2'd0 : 2'd1;
        if (e.route != 0) e.ram = 0;
        if (e.route == 2) begin
            if (wr) e.drop = 1; else e.rdata = 32'hFFFF_FFFF;
        end
        return e;
    endfunction

    // driver: one request per cycle, expected item pushed at drive time
    task automatic send(input logic [31:0] a, input logic smm, input logic wr,
                        input string tag);
        @(negedge clk);
        cfg_we = 0;
        req_valid = 1; req_addr = a; req_smm = smm; req_write = wr;
        q.push_back(model(a, smm, wr, tag));
    endtask

    task automatic cfg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        req_valid = 0;
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        shadow_write(sel, d);
        @(negedge clk);
        cfg_we = 0;
    endtask

    // register write and request in the same cycle: old settings apply
    task automatic cfg_and_send(input logic sel, input logic [7:0] d,
                                input logic [31:0] a, input string tag);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        req_valid = 1; req_addr = a; req_smm = 0; req_write = 0;
        q.push_back(model(a, 1'b0, 1'b0, tag));
        shadow_write(sel, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 0; cfg_we = 0;
        end
    endtask

    // monitor: pops and compares one cycle after each request
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected response route=%0d expected no response", rsp_route);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rsp_route !== e.route || rsp_ram_addr !== e.ram ||
                    rsp_rdata !== e.rdata || rsp_drop !== e.drop) begin
                    errors++;
                    $display("FAIL %s route=%0d ram=%h rdata=%h drop=%0b expected route=%0d ram=%h rdata=%h drop=%0b",
                             e.tag, rsp_route, rsp_ram_addr, rsp_rdata, rsp_drop,
                             e.route, e.ram, e.rdata, e.drop);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        shadow_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset rsp_valid=%0b expected 0", rsp_valid);
        end

        // R1 reset state, R10 default regions
        send(32'h000A_0000, 0, 0, "R1 low window normal");
        send(32'hFEDA_0000, 0, 0, "R1 high window normal");
        send(32'h000A_0010, 1, 0, "R1 low window smm");
        send(32'h7FF0_0010, 0, 0, "R1 tseg disabled");
        send(32'h0000_1000, 0, 0, "R10 below tolm");
        send(32'h9000_0000, 0, 1, "R10 above tolm");
        idle(1);

        // R4 open window
        cfg(0, 8'h01);
        send(32'h000A_1234, 0, 0, "R4 open low high_en=0");
        cfg(1, 8'h01);
        send(32'h000A_1234, 0, 0, "R4 open low high_en=1");
        send(32'hFEDA_1234, 0, 1, "R6 high alias translated");

        // R7 SMM view and R5 closed window
        cfg(0, 8'h05);
        cfg(1, 8'h00);
        send(32'h000A_4000, 1, 0, "R7 smm low glob");
        cfg(0, 8'h04);
        send(32'h000B_FFFC, 1, 1, "R7 smm low closed");
        send(32'h000A_4000, 0, 0, "R5 closed low");
        send(32'hFEDA_4000, 0, 0, "R5 closed high");
        cfg(1, 8'h01);
        send(32'hFEDB_FFFC, 1, 0, "R7 smm high");
        send(32'h000A_4000, 1, 0, "R7 smm low high_en=1");
        cfg(0, 8'h00);
        send(32'hFEDB_FFFC, 1, 0, "R7 smm glob clear");

        // R8 / R9 TSEG sizes and access types
        cfg(1, 8'h02);
        send(32'h7FF0_0000, 0, 0, "R9 tseg read sink");
        send(32'h7FF0_0000, 0, 1, "R9 tseg write drop");
        send(32'h7FF0_0000, 1, 0, "R9 tseg smm ram");
        send(32'h7FEF_FFFC, 0, 0, "R8 below 1MiB tseg");
        send(32'h7FFF_FFFC, 0, 0, "R8 top of tseg");
        send(32'h8000_0000, 0, 0, "R8 at tolm");
        cfg(1, 8'h06);
        send(32'h7FE0_0000, 0, 0, "R8 2MiB base");
        send(32'h7FDF_FFFC, 0, 0, "R8 below 2MiB");
        cfg(1, 8'h0A);
        send(32'h7F80_0000, 0, 0, "R8 8MiB base");
        send(32'h7F7F_FFFC, 0, 0, "R8 below 8MiB");
        cfg(1, 8'h0E);
        send(32'h7F00_0000, 0, 1, "R8 ext size base");
        send(32'h7EFF_FFFC, 0, 0, "R8 below ext size");

        // R2 same-cycle write uses old settings
        cfg_and_send(1, 8'h00, 32'h7F00_0000, "R2 same cycle old setting");
        send(32'h7F00_0000, 0, 0, "R2 next request new setting");
        idle(1);

        // R3 lock
        cfg(0, 8'h07);
        send(32'h000A_0000, 0, 0, "R3 lock forces closed");
        send(32'h000A_0000, 1, 0, "R3 glob kept with lock");
        cfg(0, 8'h01);
        send(32'h000A_0000, 0, 0, "R3 locked ctl write ignored");
        send(32'h000A_0000, 1, 0, "R3 locked glob kept");
        cfg(1, 8'h03);
        send(32'h7FF0_0000, 0, 0, "R3 locked ext write ignored");
        send(32'h000A_0000, 1, 0, "R3 locked high_en unchanged");
        idle(2);

        // R11 reset after lock
        @(negedge clk);
        rst = 1;
        shadow_reset();
        repeat (2) @(negedge clk);
        rst = 0;
        cfg(0, 8'h01);
        send(32'h000A_0000, 0, 0, "R11 open writable after reset");
        cfg(1, 8'h02);
        send(32'h7FF0_0000, 0, 0, "R11 ext writable after reset");
        idle(3);

        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R2 pending=%0d expected 0", q.size());
        end
        finish_run();
    end

endmodule